// File: doc/BRIEF.md
# Integer Execute ALU with Overflow Trap Detection

This is the combinational integer unit of the execute stage in a 32-bit load-store processor. In one pass it takes two register operands, an optional 16-bit immediate, a shift amount from the instruction and an operation select. It returns a full-width result and a flag that tells the exception logic that a trapping add or subtract has overflowed. It covers add and subtract in trapping and wrapping forms, the four bitwise operations, signed and unsigned set-on-less-than, load-upper-immediate and the three shift kinds. Each shift takes its amount either from the instruction field or from a register.

When `use_imm` is set, the immediate replaces the second operand of the non-shift operations. The unit itself picks the extension. Bitwise operations zero-extend the immediate. Arithmetic and compare operations sign-extend it, and this includes the wrapping add. Shifts always act on `b_in`.

Top module: `int_exec_alu`

## Requirements
- R1: ADD (op 0), SUB (op 2) and ADD with `use_imm`=1 raise `ovf` exactly when the true two's-complement result does not fit in 32 bits. `result` holds the low 32 bits of the sum or difference.
- R2: ADDU (op 1) and SUBU (op 3) return the wrapped 32-bit sum or difference and never raise `ovf`.
- R3: AND, OR, XOR, NOR, SLT, SLTU, LUI and all shifts (ops 4 to 13) never raise `ovf`.
- R4: For AND (op 4), OR (op 5), XOR (op 6) and NOR (op 7) with `use_imm`=1, the second operand is `{16'h0, imm16}`.
- R5: For ADD, ADDU, SUB, SUBU, SLT and SLTU with `use_imm`=1, the second operand is `imm16` sign-extended from bit 15.
- R6: SLT (op 8) returns 1 when A < B as signed numbers and 0 otherwise. SLTU (op 9) compares them as unsigned numbers. Bits 31:1 of the result are zero in both cases.
- R7: LUI (op 10) returns `{imm16, 16'h0}`.
- R8: SLL (op 11) shifts `b_in` left and fills with zeros. SRL (op 12) shifts it right and fills with zeros. SRA (op 13) shifts it right and fills with bit 31.
- R9: With `var_shift`=0 the shift amount is `shamt`. With `var_shift`=1 it is `a_in[4:0]`, and bits 31:5 of `a_in` have no effect.
- R10: NOR returns the complement of (A OR B).
- R11: Op codes 14 and 15 return zero with `ovf` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encoding in the requirements) |
| a_in | input | 32 | First operand; also carries the variable shift amount |
| b_in | input | 32 | Second register operand; the value that shifts act on |
| imm16 | input | 16 | Instruction immediate |
| use_imm | input | 1 | Use the extended immediate as the second operand |
| shamt | input | 5 | Constant shift amount from the instruction |
| var_shift | input | 1 | Take the shift amount from `a_in[4:0]` |
| result | output | 32 | Operation result |
| ovf | output | 1 | Overflow exception from a trapping add or subtract |

## Verification
The bench targets overflow at both ends of the signed range: positive wrapping to negative, and negative minus positive. A design that flags on carry-out instead would trap on harmless cases such as -1 + -1. It also checks that the wrapping forms stay silent on those same operands. Immediates with bit 15 set are fed to both bitwise and arithmetic operations, so a design that uses a single extension rule shows a wrong upper half. The signed and unsigned compares are driven with all-ones against one, where the two must disagree. Shifts of a negative value by 0, 1 and 31 expose wrong fill bits. A variable shift with junk above bit 4 of the amount exposes an amount decoder that is too wide.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10,
    OP_SLL  = 4'd11,
    OP_SRL  = 4'd12,
    OP_SRA  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  // A sum overflows when both inputs share a sign that the output lacks.
  function automatic logic add_ovf(input logic a_msb, input logic b_msb,
                                   input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  // A difference overflows when the inputs differ in sign and the output
  // sign no longer matches the minuend.
  function automatic logic sub_ovf(input logic a_msb, input logic b_msb,
                                   input logic r_msb);
    return (a_msb != b_msb) && (r_msb != a_msb);
  endfunction

  function automatic logic is_bitwise(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zero_ext,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill_bit;
  assign fill_bit = zero_ext ? 1'b0 : imm[IMM_W-1];
  assign ext      = {{PAD_W{fill_bit}}, imm};

  always_comb begin
    if (!$isunknown({zero_ext, imm}) && zero_ext)
      assert_zext_high_R4: assert (ext[DATA_W-1:IMM_W] == '0);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   diff_ext;

  assign b_eff    = do_sub ? ~b : b;
  assign sum      = a + b_eff + {{MSB{1'b0}}, do_sub};
  assign ovf_raw  = do_sub ? sub_ovf(a[MSB], b[MSB], sum[MSB])
                           : add_ovf(a[MSB], b[MSB], sum[MSB]);

  // Compare path: a separate borrow-extended difference.
  assign diff_ext    = {1'b0, a} - {1'b0, b};
  assign lt_unsigned = diff_ext[DATA_W];
  assign lt_signed   = (a[MSB] != b[MSB]) ? a[MSB] : diff_ext[MSB];

  always_comb begin
    if (!$isunknown({a, b}) && (a == b))
      assert_eq_not_less_R6: assert (!lt_signed && !lt_unsigned);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         val,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  shift_kind_e               kind,
  output logic [DATA_W-1:0]         res
);
  localparam int STAGES = $clog2(DATA_W);
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] stage_v [STAGES+1];
  logic              fill;

  assign fill       = (kind == SH_RARI) ? val[MSB] : 1'b0;
  assign stage_v[0] = val;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    localparam int SH = 1 << gi;
    always_comb begin
      if (!amt[gi])
        stage_v[gi+1] = stage_v[gi];
      else if (kind == SH_LEFT)
        stage_v[gi+1] = {stage_v[gi][DATA_W-1-SH:0], {SH{1'b0}}};
      else
        stage_v[gi+1] = {{SH{fill}}, stage_v[gi][DATA_W-1:SH]};
    end
  end

  assign res = stage_v[STAGES];

  always_comb begin
    if (!$isunknown({val, amt, kind}) && (amt != '0)) begin
      if (kind == SH_RARI)
        assert_sra_fill_R8: assert (res[MSB] == val[MSB]);
      if (kind == SH_RLOG)
        assert_srl_fill_R8: assert (res[MSB] == 1'b0);
      if (kind == SH_LEFT)
        assert_sll_fill_R8: assert (res[0] == 1'b0);
    end
  end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]                op_sel,
  input  logic [DATA_W-1:0]         a_in,
  input  logic [DATA_W-1:0]         b_in,
  input  logic [IMM_W-1:0]          imm16,
  input  logic                      use_imm,
  input  logic [$clog2(DATA_W)-1:0] shamt,
  input  logic                      var_shift,
  output logic [DATA_W-1:0]         result,
  output logic                      ovf
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W-1:0] imm_ext, opnd_b, as_sum, sh_res;
  logic [SH_W-1:0]   sh_amt;
  logic              zero_ext, do_sub, ovf_raw, lt_s, lt_u, trapping;
  shift_kind_e       sh_kind;

  assign zero_ext = is_bitwise(op_sel);
  assign opnd_b   = use_imm ? imm_ext : b_in;
  assign do_sub   = (op_sel == OP_SUB) || (op_sel == OP_SUBU);
  assign trapping = (op_sel == OP_ADD) || (op_sel == OP_SUB);
  assign sh_amt   = var_shift ? a_in[SH_W-1:0] : shamt;

  always_comb begin
    case (op_sel)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm      (imm16),
    .zero_ext (zero_ext),
    .ext      (imm_ext)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a           (a_in),
    .b           (opnd_b),
    .do_sub      (do_sub),
    .sum         (as_sum),
    .ovf_raw     (ovf_raw),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .val  (b_in),
    .amt  (sh_amt),
    .kind (sh_kind),
    .res  (sh_res)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = as_sum;
      OP_AND:  result = a_in & opnd_b;
      OP_OR:   result = a_in | opnd_b;
      OP_XOR:  result = a_in ^ opnd_b;
      OP_NOR:  result = ~(a_in | opnd_b);
      OP_SLT:  result = {{MSB{1'b0}}, lt_s};
      OP_SLTU: result = {{MSB{1'b0}}, lt_u};
      OP_LUI:  result = {imm16, {(DATA_W-IMM_W){1'b0}}};
      OP_SLL, OP_SRL, OP_SRA: result = sh_res;
      default: result = '0;
    endcase
  end

  assign ovf = trapping & ovf_raw;

  always_comb begin
    if (!$isunknown({op_sel, a_in, b_in, imm16, use_imm, shamt, var_shift})) begin
      if (!trapping)
        assert_no_overflow_R3: assert (!ovf);
      if (ovf && (op_sel == OP_ADD))
        assert_add_sign_R1: assert ((a_in[MSB] == opnd_b[MSB]) && (result[MSB] != a_in[MSB]));
      if (op_sel == OP_LUI)
        assert_lui_low_R7: assert (result[DATA_W-IMM_W-1:0] == '0);
      if ((op_sel == OP_SLT) || (op_sel == OP_SLTU))
        assert_cmp_upper_R6: assert (result[MSB:1] == '0);
      if (op_sel > OP_SRA)
        assert_unused_zero_R11: assert ((result == '0) && !ovf);
    end
  end
endmodule

// File: tb/int_exec_alu_tb.sv
module int_exec_alu_tb;
  logic        clk = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] a_in = '0, b_in = '0;
  logic [15:0] imm16 = '0;
  logic        use_imm = 1'b0, var_shift = 1'b0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  int_exec_alu u_dut (
    .op_sel(op_sel), .a_in(a_in), .b_in(b_in), .imm16(imm16),
    .use_imm(use_imm), .shamt(shamt), .var_shift(var_shift),
    .result(result), .ovf(ovf)
  );

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic ui,
      input logic [4:0] sa, input logic vs);
    logic [31:0] bo, r;
    logic [32:0] wide;
    logic [4:0]  amt;
    logic        v;
    bo = b;
    if (ui) bo = (op >= 4 && op <= 7) ? {16'h0, im} : {{16{im[15]}}, im};
    amt = vs ? a[4:0] : sa;
    v = 1'b0;
    r = 32'h0;
    case (op)
      0, 1: begin wide = {a[31], a} + {bo[31], bo}; r = wide[31:0]; v = (op == 0) && (wide[32] != wide[31]); end
      2, 3: begin wide = {a[31], a} - {bo[31], bo}; r = wide[31:0]; v = (op == 2) && (wide[32] != wide[31]); end
      4: r = a & bo;
      5: r = a | bo;
      6: r = a ^ bo;
      7: r = ~a & ~bo;
      8: r = ($signed(a) < $signed(bo)) ? 32'd1 : 32'd0;
      9: r = (a < bo) ? 32'd1 : 32'd0;
      10: r = {im, 16'h0};
      11: r = b << amt;
      12: r = b >> amt;
      13: r = $unsigned($signed(b) >>> amt);
      default: r = 32'h0;
    endcase
    return {v, r};
  endfunction

  task automatic drive(input string tag, input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic ui,
      input logic [4:0] sa, input logic vs);
    @(posedge clk);
    #1;
    op_sel = op; a_in = a; b_in = b; imm16 = im; use_imm = ui; shamt = sa; var_shift = vs;
    exp_q.push_back(model(op, a, b, im, ui, sa, vs));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge, after the driver settled inputs.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({ovf, result} !== e) begin
          failures++;
          $display("FAIL %s: got ovf=%0b result=%h expected ovf=%0b result=%h",
                   t, ovf, result, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // Reset state: all-zero inputs give zero result, no flag (R11 style idle).
    drive("R1 idle zero", 4'd0, 0, 0, 0, 0, 0, 0);
    // R1 trapping overflow
    drive("R1 add pos ovf", 4'd0, 32'h7fffffff, 32'h1, 0, 0, 0, 0);
    drive("R1 add neg ovf", 4'd0, 32'h80000000, 32'hffffffff, 0, 0, 0, 0);
    drive("R1 add no ovf -1+-1", 4'd0, 32'hffffffff, 32'hffffffff, 0, 0, 0, 0);
    drive("R1 sub ovf low", 4'd2, 32'h80000000, 32'h1, 0, 0, 0, 0);
    drive("R1 sub ovf high", 4'd2, 32'h7fffffff, 32'hffffffff, 0, 0, 0, 0);
    drive("R1 sub no ovf", 4'd2, 32'h5, 32'h9, 0, 0, 0, 0);
    drive("R1 addi ovf", 4'd0, 32'h7fffffff, 32'h0, 16'h0001, 1, 0, 0);
    // R2 wrapping forms
    drive("R2 addu wrap", 4'd1, 32'h7fffffff, 32'h1, 0, 0, 0, 0);
    drive("R2 subu wrap", 4'd3, 32'h80000000, 32'h1, 0, 0, 0, 0);
    // R5 sign extension
    drive("R5 addiu neg imm", 4'd1, 32'h10, 32'h0, 16'h8000, 1, 0, 0);
    drive("R5 addi -1", 4'd0, 32'h3, 32'h0, 16'hffff, 1, 0, 0);
    drive("R5 slti -1", 4'd8, 32'hfffffffe, 32'h0, 16'hffff, 1, 0, 0);
    drive("R5 sltiu ffff", 4'd9, 32'h7, 32'h0, 16'hffff, 1, 0, 0);
    // R4 zero extension
    drive("R4 andi", 4'd4, 32'hffffffff, 32'h0, 16'h8001, 1, 0, 0);
    drive("R4 ori", 4'd5, 32'h00000000, 32'h0, 16'hf00f, 1, 0, 0);
    drive("R4 xori", 4'd6, 32'h12345678, 32'h0, 16'hffff, 1, 0, 0);
    drive("R4 nor imm", 4'd7, 32'h0, 32'h0, 16'h8000, 1, 0, 0);
    // R6 compares
    drive("R6 slt -1<1", 4'd8, 32'hffffffff, 32'h1, 0, 0, 0, 0);
    drive("R6 sltu -1<1", 4'd9, 32'hffffffff, 32'h1, 0, 0, 0, 0);
    drive("R6 slt equal", 4'd8, 32'h80000000, 32'h80000000, 0, 0, 0, 0);
    drive("R6 sltu 1<2", 4'd9, 32'h1, 32'h2, 0, 0, 0, 0);
    // R7 LUI
    drive("R7 lui", 4'd10, 32'hdeadbeef, 32'hffffffff, 16'ha5c3, 0, 0, 0);
    // R8 shifts
    drive("R8 sll 4", 4'd11, 0, 32'h8000000f, 0, 0, 5'd4, 0);
    drive("R8 srl 1 neg", 4'd12, 0, 32'h80000000, 0, 0, 5'd1, 0);
    drive("R8 sra 1 neg", 4'd13, 0, 32'h80000000, 0, 0, 5'd1, 0);
    drive("R8 sra 31", 4'd13, 0, 32'h80000000, 0, 0, 5'd31, 0);
    drive("R8 sra 0", 4'd13, 0, 32'h80000001, 0, 0, 5'd0, 0);
    drive("R8 sra pos", 4'd13, 0, 32'h40000000, 0, 0, 5'd30, 0);
    // R9 variable shift uses low five bits
    drive("R9 sllv junk", 4'd11, 32'hffffffe5, 32'h1, 0, 0, 5'd1, 1);
    drive("R9 srav junk", 4'd13, 32'h00000123, 32'hf0000000, 0, 0, 5'd0, 1);
    drive("R9 srlv zero amt", 4'd12, 32'hffffffe0, 32'h12345678, 0, 0, 5'd7, 1);
    // R10 NOR
    drive("R10 nor", 4'd7, 32'h0f0f0000, 32'h00f000ff, 0, 0, 0, 0);
    // R3 no flag on non-trapping ops with overflow-prone operands
    drive("R3 and big", 4'd4, 32'h7fffffff, 32'h7fffffff, 0, 0, 0, 0);
    drive("R3 slt extreme", 4'd8, 32'h80000000, 32'h7fffffff, 0, 0, 0, 0);
    // R11 unused codes
    drive("R11 op14", 4'd14, 32'hffffffff, 32'hffffffff, 16'hffff, 1, 5'd3, 0);
    drive("R11 op15", 4'd15, 32'h7fffffff, 32'h1, 0, 0, 0, 0);
    // Mixed patterns over every op code (R1 R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 8 == 0) ra = {ra[31], 31'h7fffffff};
      drive("mixed R1-family", 4'(i % 16), ra, rb, 16'($urandom), 1'(i / 16),
            5'($urandom), 1'(i / 3));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule